// File: doc/BRIEF.md
# Relocatable RAM and Register Window Decoder

This block owns one mapping byte that positions a 1 KB internal RAM and a 96-byte register block inside a 16-bit address space. For every bus address it decides whether the access belongs to the RAM, the register block or neither. It then drives a select strobe for the chosen target, together with the address offset local to that target.

The RAM may sit on any 1 KB boundary. The register block sits at one of four fixed bases, picked by a two-bit code. When the two windows overlap, the register block wins.

Software changes the mapping byte through a simple write strobe. In special mode the byte may be rewritten at any time. In normal mode only a single write is accepted, and only while the bus-cycle counter started at reset is still below 64. Every clock edge counts as one bus cycle.

Top module: `amap_decoder`

## Requirements
- R1: After reset the RAM field is 0, so the RAM occupies $0000–$03FF, and the register code is 01, so the register block occupies $1000–$105F.
- R2: Bits [7:2] of the written mapping byte form the RAM field and bits [1:0] form the register code.
- R3: The register code chooses the register base: 00 gives $0000, 01 gives $1000, 10 gives $2000 and 11 gives $3000.
- R4: `regs_sel_o` is high exactly when address bits [15:12] equal the chosen base nibble and address bits [11:0] are below $060. In that case `regs_ofs_o` carries address bits [6:0].
- R5: `ram_sel_o` is high when address bits [15:10] equal the RAM field and the register block is not hit. In that case `ram_ofs_o` carries address bits [9:0].
- R6: An address inside the register window never raises `ram_sel_o`, even when it also lies inside the RAM window. The two selects are never high together.
- R7: In normal mode a write is accepted only on a clock edge where fewer than 64 cycles have passed since reset, that is, counter values 0 to 63. From counter value 64 on, writes are ignored until the next reset.
- R8: In normal mode only the first accepted write takes effect. Every later write is ignored until the next reset.
- R9: In special mode (`special_i` = 1) every write is accepted, at any cycle count, any number of times.
- R10: Each offset output is zero while its select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_i | input | 1 | 1 = special mode, 0 = normal mode; held stable between resets |
| map_wr_i | input | 1 | Write strobe for the mapping byte |
| map_wdata_i | input | 8 | Mapping byte: [7:2] RAM field, [1:0] register code |
| addr_i | input | 16 | Bus address to decode |
| ram_sel_o | output | 1 | Address targets the internal RAM |
| ram_ofs_o | output | 10 | Offset inside the RAM |
| regs_sel_o | output | 1 | Address targets the register block |
| regs_ofs_o | output | 7 | Offset inside the register block |

## Verification
The assertions watch four things on every cycle: the two selects are never high together, a register offset never reaches 96, the cycle counter never passes its limit, and the mapping byte stays frozen in normal mode once the window has closed or a write has been taken. The bench scenarios are what show the rest. They place the exact acceptance edge between counter values 63 and 64, check the decoded position of every field, cover all four register bases with a RAM window laid over them, and repeat rewrites in special mode long after the window has closed.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int ADDR_W      = 16;
  localparam int RAM_AW      = 10;
  localparam int RAM_FLD_W   = ADDR_W - RAM_AW;
  localparam int CODE_W      = 2;
  localparam int MAP_W       = RAM_FLD_W + CODE_W;
  localparam int NIB_W       = 4;
  localparam int REG_SPAN    = 96;
  localparam int REG_OFS_W   = $clog2(REG_SPAN);
  localparam int WIN_CYCLES  = 64;

  typedef struct packed {
    logic [RAM_FLD_W-1:0] ram_blk;
    logic [CODE_W-1:0]    reg_code;
  } map_t;

  localparam map_t MAP_RESET = '{ram_blk: '0, reg_code: 2'b01};

  // Base nibble of the register block: a four-entry table indexed by the code.
  function automatic logic [NIB_W-1:0] reg_base_nib(input logic [CODE_W-1:0] code);
    logic [NIB_W-1:0] nib;
    nib = '0;
    nib[CODE_W-1:0] = code;
    return nib;
  endfunction

  // True when the low part of the address lies inside the register span.
  function automatic logic in_reg_span(input logic [ADDR_W-NIB_W-1:0] low);
    return low < (ADDR_W-NIB_W)'(REG_SPAN);
  endfunction
endpackage

// File: rtl/amap_cfg_reg.sv
module amap_cfg_reg
  import amap_pkg::*;
#(
  parameter int WIN = WIN_CYCLES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             special_i,
  input  logic             wr_i,
  input  logic [MAP_W-1:0] wdata_i,
  output map_t             map_o
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cyc_cnt;
  logic             taken;
  logic             win_open;
  logic             wr_ok;
  map_t             map_q;

  assign win_open = (cyc_cnt < CNT_W'(WIN)) && !taken;
  assign wr_ok    = wr_i && (special_i || win_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
    end else if (cyc_cnt != CNT_W'(WIN)) begin
      cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= 1'b0;
      map_q <= MAP_RESET;
    end else if (wr_ok) begin
      map_q <= map_t'(wdata_i);
      if (!special_i) taken <= 1'b1;
    end
  end

  assign map_o = map_q;

  assert_cnt_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_cnt <= CNT_W'(WIN));

  assert_window_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_i && cyc_cnt == CNT_W'(WIN)) |=> $stable(map_q));

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!special_i && taken) |=> $stable(map_q));
endmodule

// File: rtl/amap_reg_dec.sv
module amap_reg_dec
  import amap_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [CODE_W-1:0]    code_i,
  output logic                 hit_o,
  output logic [REG_OFS_W-1:0] ofs_o
);
  logic nib_match;
  logic span_match;

  assign nib_match  = addr_i[ADDR_W-1 -: NIB_W] == reg_base_nib(code_i);
  assign span_match = in_reg_span(addr_i[ADDR_W-NIB_W-1:0]);
  assign hit_o      = nib_match && span_match;
  assign ofs_o      = hit_o ? addr_i[REG_OFS_W-1:0] : '0;

  always_comb begin
    if (hit_o) assert_reg_ofs_in_span_R4: assert (ofs_o < REG_OFS_W'(REG_SPAN));
  end
endmodule

// File: rtl/amap_ram_dec.sv
module amap_ram_dec
  import amap_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [RAM_FLD_W-1:0] blk_i,
  input  logic                 block_i,
  output logic                 hit_o,
  output logic [RAM_AW-1:0]    ofs_o
);
  logic blk_match;

  assign blk_match = addr_i[ADDR_W-1:RAM_AW] == blk_i;
  assign hit_o     = blk_match && !block_i;
  assign ofs_o     = hit_o ? addr_i[RAM_AW-1:0] : '0;
endmodule

// File: rtl/amap_decoder.sv
module amap_decoder
  import amap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        special_i,
  input  logic        map_wr_i,
  input  logic [7:0]  map_wdata_i,
  input  logic [15:0] addr_i,
  output logic        ram_sel_o,
  output logic [9:0]  ram_ofs_o,
  output logic        regs_sel_o,
  output logic [6:0]  regs_ofs_o
);
  map_t map_cur;
  logic reg_hit;

  amap_cfg_reg #(.WIN(WIN_CYCLES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .special_i (special_i),
    .wr_i      (map_wr_i),
    .wdata_i   (map_wdata_i),
    .map_o     (map_cur)
  );

  amap_reg_dec u_regdec (
    .addr_i (addr_i),
    .code_i (map_cur.reg_code),
    .hit_o  (reg_hit),
    .ofs_o  (regs_ofs_o)
  );

  amap_ram_dec u_ramdec (
    .addr_i  (addr_i),
    .blk_i   (map_cur.ram_blk),
    .block_i (reg_hit),
    .hit_o   (ram_sel_o),
    .ofs_o   (ram_ofs_o)
  );

  assign regs_sel_o = reg_hit;

  assert_selects_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel_o && regs_sel_o));
endmodule

// File: tb/amap_decoder_tb_top.sv
`timescale 1ns/1ps
module amap_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_i = 1'b0;
  logic        map_wr_i = 1'b0;
  logic [7:0]  map_wdata_i = 8'h00;
  logic [15:0] addr_i = 16'h0000;
  logic        ram_sel_o;
  logic [9:0]  ram_ofs_o;
  logic        regs_sel_o;
  logic [6:0]  regs_ofs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench's own view of the current placement
  logic [5:0] m_blk;
  logic [1:0] m_code;

  always #2.5 clk = ~clk;

  amap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .special_i(special_i), .map_wr_i(map_wr_i),
    .map_wdata_i(map_wdata_i), .addr_i(addr_i), .ram_sel_o(ram_sel_o),
    .ram_ofs_o(ram_ofs_o), .regs_sel_o(regs_sel_o), .regs_ofs_o(regs_ofs_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compute expected decode from requirements R3..R6, R10 and compare.
  task automatic probe(input string tag, input logic [15:0] a);
    logic [15:0] base;
    logic e_reg, e_ram;
    logic [6:0] e_gofs;
    logic [9:0] e_rofs;
    base   = {2'b00, m_code, 12'h000};
    e_reg  = (a >= base) && (a < base + 16'h0060);
    e_ram  = (a / 16'd1024 == {10'd0, m_blk}) && !e_reg;
    e_gofs = e_reg ? 7'(a - base) : 7'd0;
    e_rofs = e_ram ? 10'(a % 16'd1024) : 10'd0;
    @(negedge clk);
    addr_i = a;
    #1;
    check({tag, " regs_sel R4 R6"}, 32'(regs_sel_o), 32'(e_reg));
    check({tag, " regs_ofs R4 R10"}, 32'(regs_ofs_o), 32'(e_gofs));
    check({tag, " ram_sel R5 R6"}, 32'(ram_sel_o), 32'(e_ram));
    check({tag, " ram_ofs R5 R10"}, 32'(ram_ofs_o), 32'(e_rofs));
  endtask

  task automatic do_reset(input logic spec);
    special_i = spec;
    map_wr_i  = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_blk = 6'd0;
    m_code = 2'b01;
  endtask

  // Drive one write captured by the next rising edge.
  task automatic write_map(input logic [7:0] d);
    map_wr_i = 1'b1;
    map_wdata_i = d;
    @(negedge clk);
    map_wr_i = 1'b0;
  endtask

  task automatic t_reset_map;
    do_reset(1'b0);
    probe("r1_ram_lo", 16'h0000);
    probe("r1_ram_hi", 16'h03FF);
    probe("r1_outside", 16'h0400);
    probe("r1_reg_lo", 16'h1000);
    probe("r1_reg_hi", 16'h105F);
    probe("r1_reg_end", 16'h1060);
  endtask

  task automatic t_window_63;
    do_reset(1'b0);
    repeat (63) @(negedge clk);
    write_map({6'd5, 2'b10});  // R2: RAM at $1400, regs at $2000
    m_blk = 6'd5; m_code = 2'b10;
    probe("r7_c63_reg", 16'h2000);
    probe("r2_fld_ram", 16'h1400);
    probe("r2_ram_top", 16'h17FF);
    probe("r7_c63_oldreg", 16'h1000);
  endtask

  task automatic t_window_64;
    do_reset(1'b0);
    repeat (64) @(negedge clk);
    write_map({6'd5, 2'b10});  // must be ignored
    probe("r7_c64_reg", 16'h1000);
    probe("r7_c64_noreg", 16'h2000);
    probe("r7_c64_ram", 16'h0010);
  endtask

  task automatic t_second_write;
    do_reset(1'b0);
    repeat (10) @(negedge clk);
    write_map({6'd8, 2'b11});
    m_blk = 6'd8; m_code = 2'b11;
    repeat (2) @(negedge clk);
    write_map({6'd0, 2'b00});  // R8: ignored
    probe("r8_reg", 16'h3000);
    probe("r8_ram", 16'h2005);
    probe("r8_noreg0", 16'h0000);
  endtask

  task automatic t_special;
    do_reset(1'b1);
    repeat (120) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      logic [15:0] b;
      b = 16'(c) << 12;
      write_map({6'(c * 4), 2'(c)});  // RAM laid over the register base
      m_blk = 6'(c * 4); m_code = 2'(c);
      probe($sformatf("r9_r3_base%0d", c), b);
      probe($sformatf("r6_last%0d", c), b + 16'h005F);
      probe($sformatf("r6_after%0d", c), b + 16'h0060);
      probe($sformatf("r5_top%0d", c), b + 16'h03FF);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    t_reset_map();
    t_window_63();
    t_window_64();
    t_second_write();
    t_special();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule